// File: doc/BRIEF.md
# Register-Mapped Parallel I/O and Control Block

This block is a small peripheral with 16-bit registers on a plain synchronous register bus. Software reaches it through an address, a write strobe with write data, and a read strobe with registered read data. It holds six general control registers that are plain storage. It also holds a read-only status word, a power-control word that sets some of its own bits, and a 16-line parallel I/O port. The port has a direction register and a level register, which can be written at either of two addresses.

Each output line shows the level bit ANDed with its direction bit. The output vector is refreshed only after a bus write to the direction register or to a level register. The 16 input lines pass through a two-stage synchroniser. A rising edge on a synchronised input sets the matching level bit, and a falling edge clears it. Neither edge refreshes the output vector by itself. The block is driven by plain strobes with no back-pressure: every strobe is accepted in the cycle it is high, and a read always answers in the next cycle.

Top module: `pio_reg_block`

## Requirements
- R1: After reset, the status register reads 0x0002. Every other register reads 0x0000, and `pio_out` is 0x0000.
- R2: Only address bits [5:0] select a register, so an address that differs above bit 5 reaches the same register.
- R3: Only the low 16 bits of `wr_data` are stored. Bits [31:16] are dropped.
- R4: A write to the power register at offset 0x0C with bit 7 set stores the written value OR 0x8040. A write with bit 7 clear stores the value unchanged.
- R5: The status register at offset 0x08 is read-only and always reads 0x0002.
- R6: A write to offset 0x24 or offset 0x28 stores the write data ANDed with the current direction register.
- R7: `pio_out` equals level AND direction. It takes its new value on the clock edge after the one that accepts a write to the direction register (offset 0x20) or to a level register.
- R8: A read samples the register on the accepting edge and shows it on `rd_data` until the next edge. Offsets 0x24 and 0x28 both return the level register, and offset 0x20 returns the direction register. `rd_data` is 0 in cycles with no read.
- R9: On the third clock edge after an input line changes, a rise sets the level bit and a fall clears it, whatever the direction bit. Such a change leaves `pio_out` unchanged until the next refresh.
- R10: If a bus write to a level register and a synchronised input edge reach the level register on the same edge, the bus write fully decides the stored value.
- R11: Writes to unmapped offsets change no register. Reads of unmapped offsets return 0. Unmapped offsets are 0x2C to 0x3F and any offset that is not a multiple of 4.
- R12: The plain registers at offsets 0x00, 0x04, 0x10, 0x14, 0x18 and 0x1C read back exactly the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Byte address; only bits [5:0] are decoded |
| wr_en | input | 1 | Write strobe, accepted on the rising edge |
| wr_data | input | DATA_W (32) | Write data; the low 16 bits are used |
| rd_en | input | 1 | Read strobe, accepted on the rising edge |
| rd_data | output | 16 | Registered read data, 0 when no read |
| pio_in | input | 16 | Asynchronous input lines |
| pio_out | output | 16 | Output lines: level AND direction |

## Verification
The register contents change on the edge that accepts a write. Read data is due on the edge that accepts the read. `pio_out` is due one edge after the write to the direction or level register. A change on an input line reaches the level register on the third edge. The bench drives every stimulus at a falling edge and samples at a later falling edge. Before taking the new value of `pio_out`, it checks that the value has not yet changed at the falling edge just after the write. The case where a write and an input edge collide is arranged by counting exactly two falling edges after the input change, so that the write lands on the third rising edge.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int REG_W = 16;
  localparam int OFFS_W = 6;

  localparam logic [OFFS_W-1:0] OFF_MISC0    = 6'h00;
  localparam logic [OFFS_W-1:0] OFF_MISC1    = 6'h04;
  localparam logic [OFFS_W-1:0] OFF_STAT     = 6'h08;
  localparam logic [OFFS_W-1:0] OFF_PWR      = 6'h0C;
  localparam logic [OFFS_W-1:0] OFF_CLKSEL   = 6'h10;
  localparam logic [OFFS_W-1:0] OFF_EVT_RAW  = 6'h14;
  localparam logic [OFFS_W-1:0] OFF_EVT_MASK = 6'h18;
  localparam logic [OFFS_W-1:0] OFF_EVT_FLAG = 6'h1C;
  localparam logic [OFFS_W-1:0] OFF_DIR      = 6'h20;
  localparam logic [OFFS_W-1:0] OFF_SET      = 6'h24;
  localparam logic [OFFS_W-1:0] OFF_GET      = 6'h28;

  localparam logic [REG_W-1:0] STAT_RESET = 16'h0002;
  localparam logic [REG_W-1:0] PWR_FORCE  = 16'h8040;
  localparam int PWR_TRIGGER_BIT = 7;

  localparam int NUM_PLAIN = 6;

  function automatic logic [OFFS_W-1:0] plain_offset(input int idx);
    case (idx)
      0:       return OFF_MISC0;
      1:       return OFF_MISC1;
      2:       return OFF_CLKSEL;
      3:       return OFF_EVT_RAW;
      4:       return OFF_EVT_MASK;
      default: return OFF_EVT_FLAG;
    endcase
  endfunction
endpackage

// File: rtl/pio_in_sync.sv
module pio_in_sync #(
  parameter int W = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= pin;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stage_q[STAGES-1];
  end

  assign rise = stage_q[STAGES-1] & ~prev_q;
  assign fall = ~stage_q[STAGES-1] & prev_q;
endmodule

// File: rtl/pio_ctl_regs.sv
module pio_ctl_regs
  import pio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [OFFS_W-1:0] offs,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic              hit
);
  logic [REG_W-1:0] plain_q [NUM_PLAIN];
  logic [REG_W-1:0] pwr_q;
  logic [NUM_PLAIN-1:0] plain_sel;

  for (genvar g = 0; g < NUM_PLAIN; g++) begin : g_plain
    assign plain_sel[g] = (offs == plain_offset(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    plain_q[g] <= '0;
      else if (wr_en && plain_sel[g]) plain_q[g] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwr_q <= '0;
    else if (wr_en && offs == OFF_PWR)
      pwr_q <= wdata[PWR_TRIGGER_BIT] ? (wdata | PWR_FORCE) : wdata;
  end

  always_comb begin
    rdata = '0;
    hit   = 1'b0;
    for (int i = 0; i < NUM_PLAIN; i++) begin
      if (plain_sel[i]) begin
        rdata = plain_q[i];
        hit   = 1'b1;
      end
    end
    if (offs == OFF_PWR) begin
      rdata = pwr_q;
      hit   = 1'b1;
    end
    if (offs == OFF_STAT) begin
      rdata = STAT_RESET;
      hit   = 1'b1;
    end
  end

  // R4: a trigger-bit write leaves both forced bits high
  p_pwr_forced_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && offs == OFF_PWR && wdata[PWR_TRIGGER_BIT]) |=> (pwr_q[15] && pwr_q[6]));
endmodule

// File: rtl/pio_port.sv
module pio_port #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dir_wr,
  input  logic         lvl_wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] rise,
  input  logic [W-1:0] fall,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] lvl_q,
  output logic [W-1:0] pin_out
);
  logic         refresh_q;
  logic [W-1:0] diff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (dir_wr) dir_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lvl_q <= '0;
    else if (lvl_wr) lvl_q <= wdata & dir_q;
    else             lvl_q <= (lvl_q | rise) & ~fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) refresh_q <= 1'b0;
    else        refresh_q <= dir_wr | lvl_wr;
  end

  // pin_out doubles as the stored previous output state; only changed bits flip
  assign diff = (lvl_q & dir_q) ^ pin_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pin_out <= '0;
    else if (refresh_q) pin_out <= pin_out ^ diff;
  end

  // R6: level written by the bus never holds a bit outside the direction
  p_lvl_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_wr |=> ((lvl_q & ~$past(dir_q)) == '0));

  // R9: outputs move only on a refresh
  p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !refresh_q |=> $stable(pin_out));

  // R7: a refreshed output drives only direction-enabled lines
  p_out_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_q |=> ((pin_out & ~$past(dir_q)) == '0));
endmodule

// File: rtl/pio_reg_block.sv
module pio_reg_block
  import pio_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [REG_W-1:0]  rd_data,
  input  logic [REG_W-1:0]  pio_in,
  output logic [REG_W-1:0]  pio_out
);
  logic [OFFS_W-1:0] offs;
  logic [REG_W-1:0]  wdata16;
  logic [REG_W-1:0]  ctl_rdata;
  logic              ctl_hit;
  logic [REG_W-1:0]  dir_q, lvl_q, rise, fall;
  logic              dir_wr, lvl_wr, pio_hit;
  logic [REG_W-1:0]  rd_mux;
  logic              unused_hi;

  assign offs      = bus_addr[OFFS_W-1:0];
  assign wdata16   = wr_data[REG_W-1:0];
  assign unused_hi = ^{bus_addr[ADDR_W-1:OFFS_W], wr_data[DATA_W-1:REG_W]};

  assign dir_wr = wr_en && (offs == OFF_DIR);
  assign lvl_wr = wr_en && (offs == OFF_SET || offs == OFF_GET);

  pio_ctl_regs u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .offs  (offs),
    .wdata (wdata16),
    .rdata (ctl_rdata),
    .hit   (ctl_hit)
  );

  pio_in_sync #(.W(REG_W), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   (pio_in),
    .rise  (rise),
    .fall  (fall)
  );

  pio_port #(.W(REG_W)) u_port (
    .clk     (clk),
    .rst_n   (rst_n),
    .dir_wr  (dir_wr),
    .lvl_wr  (lvl_wr),
    .wdata   (wdata16),
    .rise    (rise),
    .fall    (fall),
    .dir_q   (dir_q),
    .lvl_q   (lvl_q),
    .pin_out (pio_out)
  );

  always_comb begin
    pio_hit = 1'b1;
    rd_mux  = ctl_rdata;
    case (offs)
      OFF_DIR:          rd_mux = dir_q;
      OFF_SET, OFF_GET: rd_mux = lvl_q;
      default:          pio_hit = 1'b0;
    endcase
    if (!pio_hit && !ctl_hit) rd_mux = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
    else            rd_data <= '0;
  end

  // R5: status always answers its fixed value
  p_stat_ro_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && offs == OFF_STAT) |=> (rd_data == STAT_RESET));

  // R11: unmapped reads answer zero
  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !ctl_hit && !pio_hit) |=> (rd_data == '0));

  // R8: no read, no data
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rd_data == '0));
endmodule

// File: tb/test_pio_reg_block.sv
module test_pio_reg_block;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data;
  logic [15:0] pio_in = '0;
  logic [15:0] pio_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pio_reg_block i_pio_reg_block (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .pio_in(pio_in), .pio_out(pio_out)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [15:0] d);
    bus_addr = a; rd_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic read_check(input string req, input logic [7:0] a, input logic [15:0] exp);
    logic [15:0] d;
    bus_read(a, d);
    check(req, d, exp);
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 pio_out", pio_out, 16'h0000);
    for (int a = 0; a <= 8'h28; a += 4)
      read_check("R1 reset value", a[7:0], (a == 8) ? 16'h0002 : 16'h0000);
    check("R8 idle rd_data", rd_data, 16'h0000);
  endtask

  task automatic t_storage();
    bus_write(8'h00, 32'h0000_1234);
    read_check("R12 offset 0x00", 8'h00, 16'h1234);
    bus_write(8'h1C, 32'h0000_BEEF);
    read_check("R12 offset 0x1C", 8'h1C, 16'hBEEF);
    bus_write(8'h18, 32'h0000_00A5);
    read_check("R12 offset 0x18", 8'h18, 16'h00A5);
    bus_write(8'h04, 32'hABCD_5A5A);
    read_check("R3 truncation", 8'h04, 16'h5A5A);
    bus_write(8'h50, 32'h0000_0F0F);
    read_check("R2 alias write", 8'h10, 16'h0F0F);
    read_check("R2 alias read", 8'hC4, 16'h5A5A);
  endtask

  task automatic t_power();
    bus_write(8'h0C, 32'h0000_0080);
    read_check("R4 forced bits", 8'h0C, 16'h80C0);
    bus_write(8'h0C, 32'h0000_0003);
    read_check("R4 plain store", 8'h0C, 16'h0003);
    bus_write(8'h0C, 32'h0000_1180);
    read_check("R4 forced merge", 8'h0C, 16'h91C0);
  endtask

  task automatic t_status();
    bus_write(8'h08, 32'h0000_FFFF);
    read_check("R5 status read-only", 8'h08, 16'h0002);
  endtask

  task automatic t_unmapped();
    bus_write(8'h2C, 32'h0000_FFFF);
    bus_write(8'h01, 32'h0000_FFFF);
    bus_write(8'h3C, 32'h0000_FFFF);
    read_check("R11 read 0x2C", 8'h2C, 16'h0000);
    read_check("R11 read 0x3C", 8'h3C, 16'h0000);
    read_check("R11 read 0x01", 8'h01, 16'h0000);
    read_check("R11 0x00 untouched", 8'h00, 16'h1234);
    read_check("R11 level untouched", 8'h24, 16'h0000);
    read_check("R11 dir untouched", 8'h20, 16'h0000);
    check("R11 pio_out untouched", pio_out, 16'h0000);
  endtask

  task automatic t_gpio();
    bus_write(8'h20, 32'h0000_00FF);
    wait_cycles(1);
    check("R7 out with zero level", pio_out, 16'h0000);
    bus_write(8'h24, 32'h0000_FFFF);
    check("R7 out not yet refreshed", pio_out, 16'h0000);
    wait_cycles(1);
    check("R7 out after level write", pio_out, 16'h00FF);
    read_check("R6 level masked 0x24", 8'h24, 16'h00FF);
    read_check("R8 level via 0x28", 8'h28, 16'h00FF);
    read_check("R8 direction 0x20", 8'h20, 16'h00FF);
    bus_write(8'h20, 32'h0000_000F);
    wait_cycles(1);
    check("R7 out after dir shrink", pio_out, 16'h000F);
    bus_write(8'h28, 32'h0000_0033);
    wait_cycles(1);
    read_check("R6 level via 0x28 masked", 8'h24, 16'h0003);
    check("R7 out after 0x28 write", pio_out, 16'h0003);
    bus_write(8'h20, 32'h0000_000F);
    bus_write(8'h24, 32'h0000_00FF);
    wait_cycles(1);
    check("R7 restore", pio_out, 16'h000F);
  endtask

  task automatic t_input();
    bus_write(8'h20, 32'h0000_00FF);
    bus_write(8'h24, 32'h0000_00FF);
    bus_write(8'h20, 32'h0000_000F);
    wait_cycles(1);
    pio_in = 16'h0101;
    wait_cycles(3);
    read_check("R9 rise sets level", 8'h24, 16'h01FF);
    check("R9 out not refreshed by rise", pio_out, 16'h000F);
    pio_in = 16'h0000;
    wait_cycles(3);
    read_check("R9 fall clears level", 8'h24, 16'h00FE);
    check("R9 out not refreshed by fall", pio_out, 16'h000F);
    bus_write(8'h20, 32'h0000_000F);
    wait_cycles(1);
    check("R9 out after refresh", pio_out, 16'h000E);
  endtask

  task automatic t_collide();
    bus_write(8'h20, 32'h0000_FFFF);
    wait_cycles(1);
    check("R7 out full dir", pio_out, 16'h00FE);
    pio_in = 16'h8000;
    wait_cycles(2);
    bus_write(8'h24, 32'h0000_0003);
    wait_cycles(1);
    read_check("R10 write wins over input", 8'h24, 16'h0003);
    check("R10 out after collision", pio_out, 16'h0003);
    wait_cycles(4);
    read_check("R10 no late input effect", 8'h24, 16'h0003);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    wait_cycles(3);
    rst_n = 1'b1;
    wait_cycles(1);
    t_reset();
    t_storage();
    t_power();
    t_status();
    t_unmapped();
    t_gpio();
    t_input();
    t_collide();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule